// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects level-sensitive interrupt request lines for a single-core processor and decides which one the core should take next. Each line carries its own enable bit, a pending bit that remembers a request even after the line drops, an active bit that marks a handler in progress, and a three-bit priority. Software reaches this state through a small register port with separate set and clear registers, so a write touches only the bits written as one.

Toward the core the block raises a request flag together with a vector number. Peripheral line `i` maps to vector `16 + i`; the sixteen lower slots of the vector table belong to the stack pointer, reset and system exceptions. The core answers with a one-cycle entry pulse when it starts the presented handler and a one-cycle exit pulse when a handler returns. A request of strictly more urgent priority than the running handler is presented even while a handler runs, which gives nested handlers. A small stack of the priorities that were entered restores the running level on each exit.

All inputs, including the request lines, are taken as synchronous to `clk`.

Top module: `irq_ctl`

## Requirements
- R1: Writing address 0 sets, and address 1 clears, the enable bit of every line whose data bit is one; zero data bits leave their enables unchanged. Reading address 0 or 1 returns the enable bits, line i at bit i.
- R2: Writing address 2 sets, and address 3 clears, the pending bit of every line whose data bit is one; reading address 2 or 3 returns the pending bits. A pending line whose enable is clear never raises `irq_req`.
- R3: A request line that is high on a clock edge while its line is not active sets its pending bit, and the bit stays set after the line goes low.
- R4: An `entry_ack` pulse while `irq_req` is high clears the pending bit and sets the active bit of the presented line on the same edge; reading address 5 returns the active bits.
- R5: Among lines that are both pending and enabled, the one with the lowest priority value is presented; on equal values the lower line index wins. The priority of line i is written and read at address 8 + i/8, bits 4*(i%8) to 4*(i%8)+2. Reset sets every priority to 0.
- R6: `irq_vec` equals 16 plus the presented line index.
- R7: While a handler runs, `irq_req` is raised only for a candidate whose priority value is strictly lower than the running handler's; equal or higher values wait.
- R8: An `exit_ack` pulse clears the active bit of the most recently entered handler and restores the running priority to that of the handler it had preempted, or to idle when none remains.
- R9: If a line is still high when its handler exits, its pending bit is set again on the edge after the exit edge.
- R10: After reset every enable, pending and active bit is zero and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NUM_IRQ | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq_req | output | 1 | An interrupt should be taken |
| irq_vec | output | VEC_W | Vector number of the presented line |
| entry_ack | input | 1 | Core enters the presented handler |
| exit_ack | input | 1 | Core returns from the current handler |

## Verification
The bench aims at ties in priority, where a design that compared with `<` in the wrong loop direction would present the higher line index. It nests a handler inside another and then checks that an equal-priority pending line stays held back after the inner exit, which a design without a priority stack, or one that reset the running level to idle on every exit, would wrongly release. It pulses a line for a single cycle to catch a controller that only follows the live level, and holds a line high across a whole handler to confirm the pending bit neither returns while the handler is active nor stays absent after the exit.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    // Vector slots reserved below the first peripheral line.
    localparam int SYS_SLOTS = 16;
    // Priority nibbles packed into one register word.
    localparam int PRIO_PER_WORD = 8;
    localparam int PRIO_NIBBLE = 4;

    typedef enum logic [3:0] {
        REG_EN_SET   = 4'd0,
        REG_EN_CLR   = 4'd1,
        REG_PEND_SET = 4'd2,
        REG_PEND_CLR = 4'd3,
        REG_ACTIVE   = 4'd5,
        REG_PRIO0    = 4'd8
    } reg_sel_e;

    function automatic logic [3:0] prio_word_addr(input int line);
        return 4'(int'(REG_PRIO0) + line / PRIO_PER_WORD);
    endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctl_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [3:0]                wr_addr,
    input  logic [31:0]               wr_data,
    output logic [NUM_IRQ-1:0]        en_q,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic [NUM_IRQ-1:0]        sw_pset,
    output logic [NUM_IRQ-1:0]        sw_pclr
);
    logic [NUM_IRQ-1:0] en_set, en_clr;
    logic [NUM_IRQ-1:0] wbits;
    logic               unused_wdata;

    assign wbits        = wr_data[NUM_IRQ-1:0];
    assign unused_wdata = ^wr_data;

    assign en_set  = (wr_en && wr_addr == REG_EN_SET)   ? wbits : '0;
    assign en_clr  = (wr_en && wr_addr == REG_EN_CLR)   ? wbits : '0;
    assign sw_pset = (wr_en && wr_addr == REG_PEND_SET) ? wbits : '0;
    assign sw_pclr = (wr_en && wr_addr == REG_PEND_CLR) ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= (en_q | en_set) & ~en_clr;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        localparam int LSB = (i % PRIO_PER_WORD) * PRIO_NIBBLE;
        logic [PRIO_W-1:0] p_q;
        always_ff @(posedge clk) begin
            if (rst)
                p_q <= '0;
            else if (wr_en && wr_addr == prio_word_addr(i))
                p_q <= wr_data[LSB +: PRIO_W];
        end
        assign prio_flat[i*PRIO_W +: PRIO_W] = p_q;
    end

endmodule

// File: rtl/irq_state.sv
module irq_state #(
    parameter int NUM_IRQ = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] sw_pset,
    input  logic [NUM_IRQ-1:0] sw_pclr,
    input  logic               entry_fire,
    input  logic [IDX_W-1:0]   entry_idx,
    input  logic               exit_fire,
    input  logic [IDX_W-1:0]   exit_idx,
    output logic [NUM_IRQ-1:0] pend_q,
    output logic [NUM_IRQ-1:0] act_q
);
    logic [NUM_IRQ-1:0] entry_oh, exit_oh, hw_set;

    assign entry_oh = entry_fire ? (NUM_IRQ'(1) << entry_idx) : '0;
    assign exit_oh  = exit_fire  ? (NUM_IRQ'(1) << exit_idx)  : '0;
    // A line being serviced does not re-pend itself until its handler exits.
    assign hw_set   = irq_in & ~act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= (pend_q | sw_pset | hw_set) & ~sw_pclr & ~entry_oh;
            act_q  <= (act_q | entry_oh) & ~exit_oh;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      any,
    output logic [IDX_W-1:0]          sel_idx,
    output logic [PRIO_W-1:0]         sel_prio
);
    // Walking from the top index down with <= lets the lowest index win ties.
    always_comb begin
        any      = 1'b0;
        sel_idx  = '0;
        sel_prio = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (cand[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] <= sel_prio)) begin
                any      = 1'b1;
                sel_idx  = IDX_W'(i);
                sel_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 3,
    parameter int SP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop,
    output logic [PRIO_W:0]   top_prio,
    output logic [IDX_W-1:0]  top_idx,
    output logic [SP_W-1:0]   sp
);
    localparam int DEPTH = 1 << PRIO_W;

    logic [PRIO_W-1:0] pr_q [DEPTH];
    logic [IDX_W-1:0]  ix_q [DEPTH];
    logic [SP_W-1:0]   sp_q, sp_m1;

    assign sp    = sp_q;
    assign sp_m1 = sp_q - SP_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (pop) begin
            sp_q <= sp_m1;
        end else if (push) begin
            pr_q[sp_q[PRIO_W-1:0]] <= push_prio;
            ix_q[sp_q[PRIO_W-1:0]] <= push_idx;
            sp_q <= sp_q + SP_W'(1);
        end
    end

    always_comb begin
        if (sp_q == '0) begin
            top_prio = {1'b1, {PRIO_W{1'b0}}};
            top_idx  = '0;
        end else begin
            top_prio = {1'b0, pr_q[sp_m1[PRIO_W-1:0]]};
            top_idx  = ix_q[sp_m1[PRIO_W-1:0]];
        end
    end

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = $clog2(SYS_SLOTS + NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [3:0]         rd_addr,
    output logic [31:0]        rd_data,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic               entry_ack,
    input  logic               exit_ack
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int SP_W  = $clog2((1 << PRIO_W) + 1);

    logic [NUM_IRQ-1:0]        en_q, pend_q, act_q, sw_pset, sw_pclr;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic                      any;
    logic [IDX_W-1:0]          sel_idx, top_idx;
    logic [PRIO_W-1:0]         sel_prio;
    logic [PRIO_W:0]           top_prio;
    logic [SP_W-1:0]           sp;
    logic                      entry_fire, exit_fire;

    irq_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en_q(en_q), .prio_flat(prio_flat), .sw_pset(sw_pset), .sw_pclr(sw_pclr)
    );

    irq_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .cand(pend_q & en_q), .prio_flat(prio_flat),
        .any(any), .sel_idx(sel_idx), .sel_prio(sel_prio)
    );

    // Strict comparison against the running level; idle reads as one past the lowest.
    assign irq_req    = any && ({1'b0, sel_prio} < top_prio);
    assign irq_vec    = VEC_W'(sel_idx) + VEC_W'(SYS_SLOTS);
    assign exit_fire  = exit_ack && (sp != '0);
    assign entry_fire = entry_ack && irq_req && !exit_ack;

    irq_state #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_state (
        .clk(clk), .rst(rst), .irq_in(irq_in), .sw_pset(sw_pset), .sw_pclr(sw_pclr),
        .entry_fire(entry_fire), .entry_idx(sel_idx),
        .exit_fire(exit_fire), .exit_idx(top_idx),
        .pend_q(pend_q), .act_q(act_q)
    );

    irq_prio_stack #(.PRIO_W(PRIO_W), .IDX_W(IDX_W), .SP_W(SP_W)) u_stack (
        .clk(clk), .rst(rst),
        .push(entry_fire), .push_prio(sel_prio), .push_idx(sel_idx),
        .pop(exit_fire),
        .top_prio(top_prio), .top_idx(top_idx), .sp(sp)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_EN_SET, REG_EN_CLR:     rd_data[NUM_IRQ-1:0] = en_q;
            REG_PEND_SET, REG_PEND_CLR: rd_data[NUM_IRQ-1:0] = pend_q;
            REG_ACTIVE:                 rd_data[NUM_IRQ-1:0] = act_q;
            default: begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    if (rd_addr == prio_word_addr(i))
                        rd_data[(i % PRIO_PER_WORD) * PRIO_NIBBLE +: PRIO_W] =
                            prio_flat[i*PRIO_W +: PRIO_W];
                end
            end
        endcase
    end

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 5,
    parameter int IDX_W   = 3,
    parameter int SP_W    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               entry_ack,
    input logic               exit_ack,
    input logic               wr_en,
    input logic [NUM_IRQ-1:0] pend_q,
    input logic [NUM_IRQ-1:0] act_q,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [IDX_W-1:0]   sel_idx,
    input logic [IDX_W-1:0]   top_idx,
    input logic [SP_W-1:0]    sp
);
    logic [IDX_W-1:0] sel_d, top_d;
    always_ff @(posedge clk) begin
        sel_d <= sel_idx;
        top_d <= top_idx;
    end

    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> |(pend_q & en_q)); // R2

    AST_ENTRY_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        (entry_ack && irq_req && !exit_ack && !wr_en) |=> !pend_q[sel_d]); // R4

    AST_ENTRY_SETS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (entry_ack && irq_req && !exit_ack) |=> act_q[sel_d]); // R4

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec >= VEC_W'(16)) && (irq_vec < VEC_W'(16 + NUM_IRQ))); // R6

    AST_ENTRY_PUSHES: assert property (@(posedge clk) disable iff (rst)
        (entry_ack && irq_req && !exit_ack) |=> sp == $past(sp) + SP_W'(1)); // R7

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_W'(1 << PRIO_W)); // R7

    AST_EXIT_POPS: assert property (@(posedge clk) disable iff (rst)
        (exit_ack && sp != '0) |=> (sp == $past(sp) - SP_W'(1)) && !act_q[top_d]); // R8

endmodule

bind irq_ctl irq_ctl_chk #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .IDX_W(IDX_W), .SP_W(SP_W)
) u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
    .entry_ack(entry_ack), .exit_ack(exit_ack), .wr_en(wr_en),
    .pend_q(pend_q), .act_q(act_q), .en_q(en_q),
    .sel_idx(sel_idx), .top_idx(top_idx), .sp(sp)
);

// File: tb/sim_irq_ctl.sv
module sim_irq_ctl;
    localparam int N = 8;
    localparam int VW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic          irq_req;
    logic [VW-1:0] irq_vec;
    logic          entry_ack = 1'b0;
    logic          exit_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_ctl #(.NUM_IRQ(N), .PRIO_W(3)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_req(irq_req), .irq_vec(irq_vec), .entry_ack(entry_ack), .exit_ack(exit_ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic enter();
        entry_ack = 1'b1;
        @(negedge clk);
        entry_ack = 1'b0;
    endtask

    task automatic leave();
        exit_ack = 1'b1;
        @(negedge clk);
        exit_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); check("R10 enable after reset", d, 32'h0);
        rd(4'd2, d); check("R10 pending after reset", d, 32'h0);
        rd(4'd5, d); check("R10 active after reset", d, 32'h0);
        check("R10 irq_req after reset", 32'(irq_req), 32'h0);
        rd(4'd8, d); check("R5 priorities after reset", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(4'd0, 32'hA5); rd(4'd0, d); check("R1 enable set", d, 32'hA5);
        wr(4'd1, 32'h05); rd(4'd1, d); check("R1 enable clear", d, 32'hA0);
        wr(4'd0, 32'h00); rd(4'd0, d); check("R1 zero write no effect", d, 32'hA0);
        wr(4'd1, 32'hFF); rd(4'd0, d); check("R1 clear all", d, 32'h0);
    endtask

    task automatic t_sw_pend();
        logic [31:0] d;
        wr(4'd2, 32'h08); rd(4'd2, d); check("R2 pending set", d, 32'h08);
        check("R2 disabled line no request", 32'(irq_req), 32'h0);
        wr(4'd0, 32'h08);
        check("R2 enabled pending requests", 32'(irq_req), 32'h1);
        check("R6 vector line 3", 32'(irq_vec), 32'd19);
        wr(4'd3, 32'h08); rd(4'd2, d); check("R2 pending clear", d, 32'h0);
        check("R2 request drops after clear", 32'(irq_req), 32'h0);
        wr(4'd1, 32'h08);
    endtask

    task automatic t_latch_entry();
        logic [31:0] d;
        wr(4'd0, 32'h04);
        irq_in[2] = 1'b1;
        @(negedge clk);
        irq_in[2] = 1'b0;
        @(negedge clk);
        rd(4'd2, d); check("R3 pending held after line low", d, 32'h04);
        check("R3 request from latched line", 32'(irq_req), 32'h1);
        check("R6 vector line 2", 32'(irq_vec), 32'd18);
        enter();
        rd(4'd2, d); check("R4 pending cleared on entry", d, 32'h0);
        rd(4'd5, d); check("R4 active set on entry", d, 32'h04);
        check("R4 no request after entry", 32'(irq_req), 32'h0);
        leave();
        rd(4'd5, d); check("R8 active cleared on exit", d, 32'h0);
        wr(4'd1, 32'hFF);
    endtask

    task automatic t_nesting();
        logic [31:0] d;
        // line1 prio 5, line4 prio 2, line5 prio 1, line6 prio 2, others 0
        wr(4'd8, 32'h0212_0050);
        rd(4'd8, d); check("R5 priority readback", d, 32'h0212_0050);
        wr(4'd0, 32'hFF);
        wr(4'd2, 32'h52);
        check("R5 tie lower index wins", 32'(irq_vec), 32'd20);
        check("R5 request present", 32'(irq_req), 32'h1);
        enter();
        check("R7 equal priority held back", 32'(irq_req), 32'h0);
        wr(4'd2, 32'h01);
        check("R7 more urgent preempts", 32'(irq_req), 32'h1);
        check("R7 preempting vector", 32'(irq_vec), 32'd16);
        enter();
        rd(4'd5, d); check("R7 nested active bits", d, 32'h11);
        check("R7 nothing above level 0", 32'(irq_req), 32'h0);
        leave();
        rd(4'd5, d); check("R8 inner exit clears line 0", d, 32'h10);
        check("R8 running level restored", 32'(irq_req), 32'h0);
        leave();
        rd(4'd5, d); check("R8 outer exit to idle", d, 32'h0);
        check("R8 idle releases request", 32'(irq_req), 32'h1);
        check("R5 next candidate line 6", 32'(irq_vec), 32'd22);
        enter(); leave();
        check("R5 lowest urgency last", 32'(irq_vec), 32'd17);
        enter(); leave();
        rd(4'd2, d); check("R4 all pending drained", d, 32'h0);
        wr(4'd1, 32'hFF);
    endtask

    task automatic t_repend();
        logic [31:0] d;
        wr(4'd0, 32'h20);
        irq_in[5] = 1'b1;
        @(negedge clk);
        check("R6 vector line 5", 32'(irq_vec), 32'd21);
        enter();
        @(negedge clk);
        rd(4'd2, d); check("R9 no re-pend while active", d, 32'h0);
        leave();
        rd(4'd2, d); check("R9 not pending on exit edge", d, 32'h0);
        @(negedge clk);
        rd(4'd2, d); check("R9 re-pend cycle after exit", d, 32'h20);
        check("R9 request again", 32'(irq_req), 32'h1);
        irq_in[5] = 1'b0;
        enter(); leave();
        wr(4'd1, 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable();
        t_sw_pend();
        t_latch_entry();
        t_nesting();
        t_repend();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule